// File: doc/BRIEF.md
# Daisy-Chainable Serial Command and Fault Port

This block is the serial side of a four-channel low-side gate pre-driver. A host frames a transfer by pulling the chip select low and then clocks bits in on `sdi`. The bits land in a shift register, and at the close of the frame they become the channel-enable command. During the same transfer, the channel fault flags shift out on `sdo`. They were captured into the shift register when the frame opened. Once those flags have gone out, the incoming `sdi` bits follow them onto `sdo`. This lets several devices share one chip select and form a daisy chain.

Each channel fault flag is sticky. A one-cycle pulse on either the open-load input or the shorted-load input of a channel sets the flag. The flag then holds until the frame closes, and closing the frame clears and re-arms it. While the battery-fault input is high, no load fault is recorded, and battery faults never appear in the serial data. The pads `cs_n`, `sclk` and `sdi` are sampled on the system clock `clk`. The pad for `sdo` is released to high impedance whenever `sdo_en` is low.

Top module: `serial_fault_port`

## Requirements
- R1: After reset (`rst_n` low), `chan_en` is 0000 and `sdo_en` is 0.
- R2: Two clocks after `cs_n` falls, `sdo_en` is 1 and `sdo` carries the captured fault flag of channel 3.
- R3: Each falling `sclk` edge inside a frame advances `sdo`. The order is the fault flags for channels 3, 2, 1 and 0, then the `sdi` bits in the order they were received, delayed by four bit times.
- R4: `sdi` is sampled on rising `sclk` edges, most significant bit first. If the number of bits in the frame is a non-zero multiple of 4, the last four bits received become `chan_en[3:0]` when `cs_n` rises. The first of those four bits drives channel 3.
- R5: A frame whose bit count is not a multiple of 4 leaves `chan_en` unchanged.
- R6: Once `cs_n` rises, `sdo_en` is 0 and stays 0 while `cs_n` remains high.
- R7: A one-cycle high pulse on `open_flt[i]` or `short_flt[i]` sets fault flag i. The flag stays set until the next rising edge of `cs_n`.
- R8: A rising edge of `cs_n` clears every fault flag. The next frame reports only faults that occurred after that edge.
- R9: While `batt_flt` is 1, load-fault pulses set no flag.
- R10: `sclk` edges while `cs_n` is high change neither `chan_en` nor `sdo_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset of all registers and flags |
| cs_n | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial bit clock |
| sdi | input | 1 | Serial data in |
| open_flt | input | 4 | Per-channel open-load fault pulses |
| short_flt | input | 4 | Per-channel shorted-load fault pulses |
| batt_flt | input | 1 | Battery over/under-voltage present; blocks load-fault capture |
| sdo | output | 1 | Serial data out |
| sdo_en | output | 1 | Drive enable for the `sdo` pad; low means high impedance |
| chan_en | output | 4 | Channel-enable command, bit i drives channel i |

## Verification
The assertions assume that `cs_n`, `sclk` and `sdi` are already synchronous to `clk`. They also assume that each level of these pins is held for at least one clock, so that every edge is seen exactly once. The bench drives all pins at the falling edge of `clk` and holds each `sclk` level for two clocks. It changes `sdi` only while `sclk` is low and keeps `sclk` low whenever `cs_n` moves. With this stimulus, every rising and falling serial edge falls cleanly inside or outside a frame.

// File: rtl/serial_fault_port.sv
module serial_fault_port #(
  parameter int CH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sclk,
  input  logic          sdi,
  input  logic [CH-1:0] open_flt,
  input  logic [CH-1:0] short_flt,
  input  logic          batt_flt,
  output logic          sdo,
  output logic          sdo_en,
  output logic [CH-1:0] chan_en
);
  localparam int CW = (CH > 1) ? $clog2(CH) : 1;

  logic          cs_q, sclk_q, got_bits;
  logic [CW-1:0] phase;
  logic [CH-1:0] flags, shreg;

  wire in_frame = ~cs_q & ~cs_n;
  wire cs_fall  = cs_q & ~cs_n;
  wire cs_rise  = ~cs_q & cs_n;
  wire sck_up   = in_frame & sclk & ~sclk_q;
  wire sck_dn   = in_frame & ~sclk & sclk_q;
  wire aligned  = got_bits && (phase == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      cs_q   <= cs_n;
      sclk_q <= sclk;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flags <= '0;
    else if (cs_rise)
      flags <= '0;
    else if (!batt_flt)
      flags <= flags | open_flt | short_flt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= '0;
      phase    <= '0;
      got_bits <= 1'b0;
      sdo      <= 1'b0;
    end else if (cs_fall) begin
      shreg    <= flags;
      phase    <= '0;
      got_bits <= 1'b0;
      sdo      <= flags[CH-1];
    end else begin
      if (sck_up) begin
        shreg    <= {shreg[CH-2:0], sdi};
        phase    <= (phase == CW'(CH-1)) ? '0 : phase + 1'b1;
        got_bits <= 1'b1;
      end
      if (sck_dn)
        sdo <= shreg[CH-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdo_en  <= 1'b0;
      chan_en <= '0;
    end else begin
      if (cs_fall) sdo_en <= 1'b1;
      if (cs_rise) begin
        sdo_en <= 1'b0;
        if (aligned) chan_en <= shreg;
      end
    end
  end
endmodule

module serial_fault_port_checks #(
  parameter int CH = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          sdo_en,
  input logic [CH-1:0] chan_en
);
  assert_drive_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |=> sdo_en);

  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> !sdo_en);

  assert_idle_hiz_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && !$past(sdo_en)) |=> !sdo_en);

  assert_cmd_only_at_close_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(cs_n) |=> $stable(chan_en));

  assert_idle_cmd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n)) |=> $stable(chan_en));
endmodule

bind serial_fault_port serial_fault_port_checks #(.CH(CH)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdo_en(sdo_en), .chan_en(chan_en)
);

// File: tb/serial_fault_port_tb.sv
module serial_fault_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, batt_flt = 1'b0;
  logic [3:0] open_flt = '0, short_flt = '0;
  logic       sdo, sdo_en;
  logic [3:0] chan_en;

  int total = 0, bad = 0;
  bit exp_q[$];
  event smp;
  logic [3:0] exp_cmd = '0;

  always #10 clk = ~clk;

  serial_fault_port dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .open_flt(open_flt), .short_flt(short_flt), .batt_flt(batt_flt),
    .sdo(sdo), .sdo_en(sdo_en), .chan_en(chan_en)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(smp);
      if (exp_q.size() == 0) chk("R3 queue", 4'd1, 4'd0);
      else chk("R3 sdo", {3'b0, sdo}, {3'b0, exp_q.pop_front()});
    end
  end

  task automatic pulse(input logic [3:0] o, input logic [3:0] s);
    open_flt = o; short_flt = s;
    waitn(1);
    open_flt = '0; short_flt = '0;
    waitn(1);
  endtask

  task automatic frame(input logic [3:0] flt, input int n, input logic [15:0] bits);
    bit stream[$];
    for (int i = 3; i >= 0; i--) stream.push_back(flt[i]);
    for (int i = n - 1; i >= 0; i--) stream.push_back(bits[i]);
    cs_n = 1'b0;
    waitn(2);
    chk("R2 sdo_en", {3'b0, sdo_en}, 4'd1);
    exp_q.push_back(stream[0]);
    -> smp;
    for (int k = 0; k < n; k++) begin
      sdi = bits[n - 1 - k];
      waitn(2);
      sclk = 1'b1;
      waitn(2);
      sclk = 1'b0;
      waitn(2);
      exp_q.push_back(stream[k + 1]);
      -> smp;
    end
    cs_n = 1'b1;
    waitn(2);
    chk("R6 sdo_en", {3'b0, sdo_en}, 4'd0);
    if (n > 0 && n % 4 == 0) exp_cmd = bits[3:0];
    chk((n % 4 == 0) ? "R4 chan_en" : "R5 chan_en", chan_en, exp_cmd);
  endtask

  initial begin
    fork
      begin
        waitn(20000);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
      end
      begin
        waitn(3);
        chk("R1 chan_en", chan_en, 4'd0);
        chk("R1 sdo_en", {3'b0, sdo_en}, 4'd0);
        rst_n = 1'b1;
        waitn(2);
        // R10: serial clocks with the port deselected
        for (int i = 0; i < 3; i++) begin
          sdi = 1'b1; sclk = 1'b1; waitn(2); sclk = 1'b0; waitn(2);
        end
        chk("R10 chan_en", chan_en, 4'd0);
        chk("R10 sdo_en", {3'b0, sdo_en}, 4'd0);
        // R7: short pulse on ch1, sticky until frame close
        pulse(4'b0000, 4'b0010);
        waitn(5);
        frame(4'b0010, 4, 16'b1010);
        // R8: flags cleared by the previous close; 8-bit chained frame
        frame(4'b0000, 8, 16'b1100_0101);
        // R5: 3 bits, command kept; open pulse on ch3 and ch0 reported
        pulse(4'b1001, 4'b0000);
        frame(4'b1001, 3, 16'b111);
        // R9: pulses during a battery fault are not recorded
        batt_flt = 1'b1;
        pulse(4'b1000, 4'b0100);
        batt_flt = 1'b0;
        waitn(1);
        frame(4'b0000, 4, 16'b0000);
        pulse(4'b0001, 4'b0000);
        frame(4'b0001, 12, 16'b0110_0000_0011);
        chk("R4 final chan_en", chan_en, 4'b0011);
        chk("R3 drained", exp_q.size() == 0 ? 4'd0 : 4'd1, 4'd0);
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule